// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each incoming frame, whether the frame's 48-bit destination address is accepted. The address arrives one byte per cycle on a small streaming input. The first byte is flagged with a start strobe, and bytes arrive in wire order. While the bytes arrive, the block runs a bit-reflected CRC-32 over them. It also collects the address so that it can be compared with the station's own address.

When the sixth byte has been taken, the block makes its decision. Promiscuous mode accepts every frame, and the all-ones broadcast address is always accepted. Any other group address is accepted only if its bit in a 64-bit hash table is set; six CRC bits choose that bit. A unicast address must equal the programmed station address exactly. The result comes with a one-cycle done strobe. Configuration inputs are sampled directly and are expected to stay steady while an address is being evaluated.

Top module: `mcast_hash_filter`

## Requirements
- R1: While reset is held, and in the first cycle after its release, out_done and out_accept are both 0.
- R2: out_done is high for exactly one cycle, in the cycle after the edge at which the sixth byte of an evaluation is taken. Cycles with in_valid low may fall between the bytes; each such cycle delays the strobe by one cycle.
- R3: The hash is a CRC-32 using reflected polynomial 0xEDB88320. The register is preset to all ones. The bytes are fed in arrival order, least significant bit first, and the result is not inverted. The hash index is bits [31:26] of the result.
- R4: A hash index i selects bit i of cfg_hash. That is bit index[3:0] of filter word index[5:4], and filter word w sits at cfg_hash[16w+15:16w].
- R5: An address whose first byte has bit 0 set is a group address, and it is accepted exactly when the table bit it selects is 1. With cfg_hash all ones, every group address is accepted.
- R6: An address whose first byte has bit 0 clear is accepted only when all 48 bits equal cfg_station. Byte k of the address, counted from 0 in arrival order, is compared with cfg_station[8k+7:8k].
- R7: The broadcast address (all 48 bits set) is accepted even when the hash table is all zeros.
- R8: When cfg_mode[15] is 1, every address is accepted. The other bits of cfg_mode have no effect.
- R9: in_start together with in_valid in the middle of an address abandons that address, and no done is produced for it. The strobed byte becomes byte 0 of a new address, and the CRC restarts from all ones.
- R10: Bytes with in_valid low are ignored. Valid bytes that arrive with no address in progress and without in_start are also ignored and produce no done.
- R11: out_accept is 0 in every cycle in which out_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_station | input | 48 | Station address, byte k at bits [8k+7:8k] |
| cfg_hash | input | 64 | Four 16-bit filter words, word w at [16w+15:16w] |
| cfg_mode | input | 16 | Mode word, bit 15 selects promiscuous mode |
| in_start | input | 1 | Marks the current valid byte as the first address byte |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Address byte |
| out_done | output | 1 | One-cycle strobe: a decision is ready |
| out_accept | output | 1 | Decision: 1 accepts the frame |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- the strobe rules: accept never appears without done, done never lasts two cycles, and done always follows a valid byte;
- a start byte never produces done in the next cycle;
- promiscuous mode and a completed broadcast address always lead to acceptance.

Only the bench's scenarios can show that the CRC and the hash index are correct. They do this by sweeping many pseudo-random group addresses against single-bit, inverted and single-word tables. The same applies to the exact unicast compare, which the bench tests by flipping each address bit in turn, and to the restart behaviour after an aborted address.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int NB       = 6,
  parameter int HB       = 6,
  parameter int PROM_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8*NB-1:0]   cfg_station,
  input  logic [2**HB-1:0]  cfg_hash,
  input  logic [15:0]       cfg_mode,
  input  logic              in_start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              out_done,
  output logic              out_accept
);
  localparam int          AW   = 8 * NB;
  localparam int          CW   = $clog2(NB + 1);
  localparam logic [31:0] POLY = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic          active;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic [AW-1:0] da;
  logic [AW-1:0] da_nxt;

  wire           take    = in_valid && (in_start || active);
  wire [CW-1:0]  pos     = in_start ? '0 : cnt;
  wire           last    = take && (pos == CW'(NB - 1));
  wire [31:0]    crc_nxt = crc_step(in_start ? 32'hFFFFFFFF : crc, in_byte);
  wire [HB-1:0]  idx     = crc_nxt[31 -: HB];

  always_comb begin
    da_nxt = da;
    da_nxt[8*pos +: 8] = in_byte;
  end

  wire is_grp  = da_nxt[0];
  wire is_bc   = &da_nxt;
  wire uni_ok  = (da_nxt == cfg_station);
  wire verdict = cfg_mode[PROM_BIT] | is_bc | (is_grp ? cfg_hash[idx] : uni_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      crc        <= '1;
      da         <= '0;
      out_done   <= 1'b0;
      out_accept <= 1'b0;
    end else begin
      out_done   <= last;
      out_accept <= last && verdict;
      if (take) begin
        crc    <= crc_nxt;
        da     <= da_nxt;
        cnt    <= pos + CW'(1);
        active <= !last;
      end
    end
  end

  // R11
  accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_accept |-> out_done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R2
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid));

  // R9
  start_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> !out_done);

  // R8
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && $past(cfg_mode[PROM_BIT])) |-> out_accept);

  // R7
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && active && cnt == CW'(NB - 1) &&
     in_byte == 8'hFF && da[AW-9:0] == '1) |=> out_accept);
endmodule

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;
  logic        clk = 0;
  logic        rst_n;
  logic [47:0] cfg_station;
  logic [63:0] cfg_hash;
  logic [15:0] cfg_mode;
  logic        in_start, in_valid;
  logic [7:0]  in_byte;
  logic        out_done, out_accept;

  int n_cmp = 0;
  int n_bad = 0;
  logic [47:0] seed = 48'h1234_5678_9ABC;

  always #5 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rst_n(rst_n), .cfg_station(cfg_station), .cfg_hash(cfg_hash),
    .cfg_mode(cfg_mode), .in_start(in_start), .in_valid(in_valid), .in_byte(in_byte),
    .out_done(out_done), .out_accept(out_accept));

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {done,accept} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic next_rand(output logic [47:0] v);
    seed = seed * 48'h5_DEEC_E66D + 48'd11;
    v = seed ^ (seed >> 17);
  endtask

  // Starts and ends on a falling edge.
  task automatic send(input logic [47:0] a, input int gap, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      in_valid = 1'b1;
      in_start = (k == 0);
      in_byte  = a[8*k +: 8];
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
      if (k < 5) begin
        // R2 R11: nothing before the sixth byte
        chk("R2 early", {out_done, out_accept}, 2'b00);
        repeat (gap) @(negedge clk);
      end
    end
  endtask

  task automatic eval(input logic [47:0] a, input int gap, input logic exp, input string tag);
    send(a, gap, 6);
    chk(tag, {out_done, out_accept}, {1'b1, exp});
    @(negedge clk);
    chk("R2 pulse", {out_done, out_accept}, 2'b00);
  endtask

  initial begin
    #1_900_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    rst_n = 0; in_start = 0; in_valid = 0; in_byte = 0;
    cfg_station = 48'h5544_3322_1100; cfg_hash = '0; cfg_mode = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {out_done, out_accept}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {out_done, out_accept}, 2'b00);

    // R3 R4 R5: hash sweep
    for (int i = 0; i < 256; i++) begin
      next_rand(a);
      a[0] = 1'b1;
      if (&a) a[1] = 1'b0;
      ix = ref_idx(a);
      cfg_hash = 64'd1 << ix;
      eval(a, i % 3, 1'b1, "R3 R4 single bit hit");
      cfg_hash = ~(64'd1 << ix);
      eval(a, 0, 1'b0, "R4 cleared bit miss");
      cfg_hash = 64'hFFFF << (16 * (i % 4));
      eval(a, 1, (ix[5:4] == 2'(i % 4)), "R4 word select");
      if (i % 8 == 0) begin
        cfg_hash = '1;
        eval(a, 0, 1'b1, "R5 all ones");
      end
    end

    // R6: unicast exact match
    cfg_hash = '0;
    cfg_station = 48'hA1B2_C3D4_E5F6 & ~48'd1;
    eval(cfg_station, 0, 1'b1, "R6 match");
    for (int b = 0; b < 48; b++)
      eval(cfg_station ^ (48'd1 << b), b % 2, 1'b0, "R6 one bit off");

    // R7: broadcast
    eval(48'hFFFF_FFFF_FFFF, 2, 1'b1, "R7 broadcast");

    // R8: promiscuous, and other mode bits inert
    cfg_mode = 16'h8000;
    for (int i = 0; i < 16; i++) begin
      next_rand(a);
      eval(a, 0, 1'b1, "R8 promisc");
    end
    cfg_mode = 16'h7FFF;
    for (int i = 0; i < 16; i++) begin
      next_rand(a);
      a[0] = 1'b0;
      eval(a, 0, (a == cfg_station), "R8 other mode bits");
    end
    cfg_mode = '0;

    // R9: abort mid-address, restart
    send(cfg_station, 0, 3);
    eval(cfg_station ^ 48'h10_0000, 0, 1'b0, "R9 restart mismatch");
    send(48'h0102_0304_0507, 1, 4);
    eval(cfg_station, 0, 1'b1, "R9 restart match");
    next_rand(a);
    a[0] = 1'b1;
    ix = ref_idx(a);
    cfg_hash = 64'd1 << ix;
    send(48'hFFFF_FFFF_FFFF, 0, 5);
    eval(a, 0, 1'b1, "R9 crc restarts");

    // R10: bytes without start, or without valid, are ignored
    for (int k = 0; k < 8; k++) begin
      in_valid = 1'b1;
      in_start = 1'b0;
      in_byte  = 8'hFF;
      @(negedge clk);
      chk("R10 no start", {out_done, out_accept}, 2'b00);
    end
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_start = 1'b1;
      @(negedge clk);
      chk("R10 no valid", {out_done, out_accept}, 2'b00);
    end
    in_start = 1'b0;
    eval(cfg_station, 0, 1'b1, "R10 normal after idle");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule